// File: doc/BRIEF.md
# Wavefront Issue Scheduler with Register-File Read Arbitration

Every clock cycle this block chooses at most one ready wavefront for each execution resource of a compute unit. The resources are a group of SIMD pipelines followed by a group of global-memory pipelines and a group of shared-memory pipelines. Each resource has its own ready bitmask over all wavefronts and its own round-robin selector. Each wavefront carries the id of the SIMD unit whose vector register file it uses, and a bit vector naming the register-file banks its next instruction reads.

Once all resources have picked, a second combinational pass resolves read-port collisions. It walks the memory pipes in index order. A memory-pipe pick wins against any other surviving pick that sits on the same SIMD and whose bank vector overlaps its own. The loser's slot is emptied and the loser is reported as ready again. The surviving picks land in registered dispatch slots and are reported as blocked. Write-port collisions are not examined.

Top module: `wave_issue_sched`

## Requirements
- R1: A resource dispatches only a wavefront whose bit is set in its own ready mask (bit `r*NUM_WAVES + w` for resource r and wave w); the result appears in the dispatch slot one clock edge after the mask is presented.
- R2: A resource whose ready mask is all zero shows an invalid slot after that edge, and an invalid slot always reads wave index zero.
- R3: Every surviving pick makes its slot valid with the chosen wave index and sets that wave's bit in `statusBlocked` for one cycle.
- R4: Each resource searches round-robin, starting at the wave after its pointer and wrapping. The pointer becomes the picked wave whenever the mask is non-empty, even if the pick is later displaced. After reset the pointer is 0, so wave 1 is tried first.
- R5: If a memory-pipe pick and another surviving pick have equal SIMD ids and overlapping bank vectors, the other slot is emptied and its wave's bit is set in `statusReady` for one cycle (unless the same wave also survives elsewhere).
- R6: Picks on different SIMD ids, or with disjoint bank vectors, never displace each other.
- R7: Each memory pipe displaces at most one pick: the lowest-indexed conflicting surviving slot. A slot emptied earlier in the pass no longer takes part.
- R8: SIMD-pipe picks never displace each other, whatever their banks.
- R9: A synchronous reset empties all slots, clears both status vectors and returns all round-robin pointers to 0.
- R10: Resource indices 0 to NUM_SIMD-1 are SIMD pipes, the next NUM_GMEM are global-memory pipes and the last NUM_SMEM are shared-memory pipes. Memory pipes are processed in increasing index, so a lower memory pipe wins over a higher one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| readyMask | input | NUM_RES*NUM_WAVES | Ready set of each resource; resource r occupies bits [r*NUM_WAVES +: NUM_WAVES] |
| waveSimd | input | NUM_WAVES*SIMD_W | SIMD id of each wave; wave w occupies [w*SIMD_W +: SIMD_W] |
| waveBanks | input | NUM_WAVES*NUM_BANKS | Register-file bank read requests of each wave; wave w occupies [w*NUM_BANKS +: NUM_BANKS] |
| dispValid | output | NUM_RES | Dispatch slot filled, one bit per resource |
| dispWave | output | NUM_RES*WAVE_W | Wave index in each slot; resource r occupies [r*WAVE_W +: WAVE_W] |
| statusBlocked | output | NUM_WAVES | One-cycle pulse per wave dispatched this cycle |
| statusReady | output | NUM_WAVES | One-cycle pulse per wave displaced back to ready |

## Verification
The hardest situation to reach is a chain of displacements inside one cycle. In that case an earlier memory pipe empties a SIMD slot, and a later memory pipe then skips that emptied slot and displaces the earlier memory pipe itself. Because every ready mask in the stimulus is one-hot, each pick is known in advance, so directed cycles can put three waves on one SIMD with overlapping banks. Random cycles then narrow the SIMD ids and bank vectors so that collisions are common and pointer wrap-around is exercised.

// File: rtl/wave_sched_pkg.sv
package wave_sched_pkg;
  localparam int NUM_SIMD  = 4;
  localparam int NUM_GMEM  = 1;
  localparam int NUM_SMEM  = 1;
  localparam int NUM_MEM   = NUM_GMEM + NUM_SMEM;
  localparam int NUM_RES   = NUM_SIMD + NUM_MEM;
  localparam int NUM_WAVES = 8;
  localparam int NUM_BANKS = 4;
  localparam int WAVE_W    = (NUM_WAVES > 1) ? $clog2(NUM_WAVES) : 1;
  localparam int SIMD_W    = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1;

  typedef logic [WAVE_W-1:0] wave_idx_t;

  // Strobes from the selection/arbitration control to the register datapath
  typedef struct packed {
    logic [NUM_RES-1:0]   fill;        // slot survives arbitration
    logic [NUM_RES-1:0]   advance;     // round-robin pointer moves to pick
    logic [NUM_WAVES-1:0] markBlocked;
    logic [NUM_WAVES-1:0] markReady;
  } issue_strobe_t;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         any,
  output logic [W-1:0] pick
);
  // R4: search begins just after the pointer and wraps around
  always_comb begin
    int idx;
    any  = 1'b0;
    pick = '0;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(ptr) + k) % N;
      if (!any && req[idx]) begin
        any  = 1'b1;
        pick = W'(idx);
      end
    end
  end
endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import wave_sched_pkg::*;
(
  input  logic [NUM_RES*NUM_WAVES-1:0]   readyMask,
  input  logic [NUM_RES*WAVE_W-1:0]      ptrFlat,
  input  logic [NUM_WAVES*SIMD_W-1:0]    waveSimd,
  input  logic [NUM_WAVES*NUM_BANKS-1:0] waveBanks,
  output issue_strobe_t                  strobe,
  output logic [NUM_RES*WAVE_W-1:0]      pickFlat
);
  logic [NUM_RES-1:0] anyVec;
  wave_idx_t          pick [NUM_RES];

  // One independent selector per execution resource (R1, R4)
  for (genvar r = 0; r < NUM_RES; r++) begin : g_sel
    rr_picker #(.N(NUM_WAVES), .W(WAVE_W)) u_pick (
      .req (readyMask[r*NUM_WAVES +: NUM_WAVES]),
      .ptr (ptrFlat[r*WAVE_W +: WAVE_W]),
      .any (anyVec[r]),
      .pick(pick[r])
    );
    assign pickFlat[r*WAVE_W +: WAVE_W] = pick[r];
  end

  function automatic logic collide(input wave_idx_t a, input wave_idx_t b);
    logic sameSimd;
    logic bankHit;
    sameSimd = waveSimd[int'(a)*SIMD_W +: SIMD_W] == waveSimd[int'(b)*SIMD_W +: SIMD_W];
    bankHit  = |(waveBanks[int'(a)*NUM_BANKS +: NUM_BANKS] &
                 waveBanks[int'(b)*NUM_BANKS +: NUM_BANKS]);
    return sameSimd && bankHit;
  endfunction

  // Second pass: memory pipes in index order win read-port collisions (R5..R8, R10)
  always_comb begin
    logic [NUM_RES-1:0]   alive;
    logic [NUM_WAVES-1:0] blk;
    logic [NUM_WAVES-1:0] rdy;
    logic                 done;
    alive = anyVec;
    for (int j = NUM_SIMD; j < NUM_RES; j++) begin
      done = 1'b0;
      if (alive[j]) begin
        for (int i = 0; i < NUM_RES; i++) begin
          if (!done && i != j && alive[i] && collide(pick[j], pick[i])) begin
            alive[i] = 1'b0;
            done     = 1'b1;
          end
        end
      end
    end
    blk = '0;
    rdy = '0;
    for (int r = 0; r < NUM_RES; r++) begin
      if (alive[r]) blk[pick[r]] = 1'b1;
      if (anyVec[r] && !alive[r]) rdy[pick[r]] = 1'b1;
    end
    strobe.fill        = alive;
    strobe.advance     = anyVec;
    strobe.markBlocked = blk;
    strobe.markReady   = rdy & ~blk;
  end
endmodule

// File: rtl/issue_dp.sv
module issue_dp
  import wave_sched_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  issue_strobe_t             strobe,
  input  logic [NUM_RES*WAVE_W-1:0] pickFlat,
  output logic [NUM_RES*WAVE_W-1:0] ptrFlat,
  output logic [NUM_RES-1:0]        dispValid,
  output logic [NUM_RES*WAVE_W-1:0] dispWave,
  output logic [NUM_WAVES-1:0]      statusBlocked,
  output logic [NUM_WAVES-1:0]      statusReady
);
  // R9: synchronous reset of slots, status and pointers
  always_ff @(posedge clk) begin
    if (rst) begin
      ptrFlat       <= '0;
      dispValid     <= '0;
      dispWave      <= '0;
      statusBlocked <= '0;
      statusReady   <= '0;
    end else begin
      dispValid     <= strobe.fill;
      statusBlocked <= strobe.markBlocked;
      statusReady   <= strobe.markReady;
      for (int r = 0; r < NUM_RES; r++) begin
        dispWave[r*WAVE_W +: WAVE_W] <= strobe.fill[r] ? pickFlat[r*WAVE_W +: WAVE_W] : '0;
        if (strobe.advance[r]) ptrFlat[r*WAVE_W +: WAVE_W] <= pickFlat[r*WAVE_W +: WAVE_W];
      end
    end
  end
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
  import wave_sched_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_RES*NUM_WAVES-1:0]   readyMask,
  input  logic [NUM_WAVES*SIMD_W-1:0]    waveSimd,
  input  logic [NUM_WAVES*NUM_BANKS-1:0] waveBanks,
  output logic [NUM_RES-1:0]             dispValid,
  output logic [NUM_RES*WAVE_W-1:0]      dispWave,
  output logic [NUM_WAVES-1:0]           statusBlocked,
  output logic [NUM_WAVES-1:0]           statusReady
);
  issue_strobe_t             strobe;
  logic [NUM_RES*WAVE_W-1:0] pickFlat;
  logic [NUM_RES*WAVE_W-1:0] ptrFlat;

  issue_ctrl u_ctrl (
    .readyMask(readyMask),
    .ptrFlat  (ptrFlat),
    .waveSimd (waveSimd),
    .waveBanks(waveBanks),
    .strobe   (strobe),
    .pickFlat (pickFlat)
  );

  issue_dp u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .pickFlat     (pickFlat),
    .ptrFlat      (ptrFlat),
    .dispValid    (dispValid),
    .dispWave     (dispWave),
    .statusBlocked(statusBlocked),
    .statusReady  (statusReady)
  );
endmodule

// File: rtl/wave_sched_chk.sv
module wave_sched_chk
  import wave_sched_pkg::*;
(
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_RES*NUM_WAVES-1:0] readyMask,
  input logic [NUM_RES-1:0]           dispValid,
  input logic [NUM_RES*WAVE_W-1:0]    dispWave,
  input logic [NUM_WAVES-1:0]         statusBlocked,
  input logic [NUM_WAVES-1:0]         statusReady
);
  logic [NUM_RES*NUM_WAVES-1:0] readyQ;
  always_ff @(posedge clk) readyQ <= readyMask;

  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    p_was_ready_r1: assert property (@(posedge clk) disable iff (rst)
      dispValid[r] |-> readyQ[r*NUM_WAVES + int'(dispWave[r*WAVE_W +: WAVE_W])]);
    p_empty_skip_r2: assert property (@(posedge clk) disable iff (rst)
      (readyQ[r*NUM_WAVES +: NUM_WAVES] == '0) |-> !dispValid[r]);
    p_blocked_r3: assert property (@(posedge clk) disable iff (rst)
      dispValid[r] |-> statusBlocked[int'(dispWave[r*WAVE_W +: WAVE_W])]);
  end

  p_displace_bound_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(statusReady) <= NUM_MEM);
endmodule

bind wave_issue_sched wave_sched_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .readyMask    (readyMask),
  .dispValid    (dispValid),
  .dispWave     (dispWave),
  .statusBlocked(statusBlocked),
  .statusReady  (statusReady)
);

// File: tb/sim_wave_issue_sched.sv
module sim_wave_issue_sched;
  import wave_sched_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_RES*NUM_WAVES-1:0]   readyMask = '0;
  logic [NUM_WAVES*SIMD_W-1:0]    waveSimd  = '0;
  logic [NUM_WAVES*NUM_BANKS-1:0] waveBanks = '0;
  logic [NUM_RES-1:0]             dispValid;
  logic [NUM_RES*WAVE_W-1:0]      dispWave;
  logic [NUM_WAVES-1:0]           statusBlocked;
  logic [NUM_WAVES-1:0]           statusReady;

  int errors = 0;
  int checks = 0;
  int mPtr [NUM_RES];

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_issue_sched u0 (.*);

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int simdOf(int w);
    return int'(waveSimd[w*SIMD_W +: SIMD_W]);
  endfunction

  function automatic logic [NUM_BANKS-1:0] banksOf(int w);
    return waveBanks[w*NUM_BANKS +: NUM_BANKS];
  endfunction

  task automatic setWave(input int w, input int s, input logic [NUM_BANKS-1:0] b);
    waveSimd[w*SIMD_W +: SIMD_W]         = SIMD_W'(s);
    waveBanks[w*NUM_BANKS +: NUM_BANKS] = b;
  endtask

  task automatic setReady(input int r, input int w);
    readyMask[r*NUM_WAVES + w] = 1'b1;
  endtask

  // Inputs are already driven at a falling edge; model, clock once, compare at the next falling edge
  task automatic step(input string tag);
    int  pk [NUM_RES];
    bit  got [NUM_RES];
    bit  live [NUM_RES];
    logic [NUM_RES-1:0]        eValid;
    logic [NUM_RES*WAVE_W-1:0] eWave;
    logic [NUM_WAVES-1:0]      eBlk;
    logic [NUM_WAVES-1:0]      eRdy;
    for (int r = 0; r < NUM_RES; r++) begin
      got[r] = 0;
      pk[r]  = 0;
      for (int k = 1; k <= NUM_WAVES; k++) begin
        int w;
        w = (mPtr[r] + k) % NUM_WAVES;
        if (!got[r] && readyMask[r*NUM_WAVES + w]) begin
          got[r] = 1;
          pk[r]  = w;
        end
      end
      live[r] = got[r];
    end
    for (int j = NUM_SIMD; j < NUM_RES; j++) begin
      if (live[j]) begin
        for (int i = 0; i < NUM_RES; i++) begin
          if (i != j && live[i] && simdOf(pk[j]) == simdOf(pk[i]) &&
              (banksOf(pk[j]) & banksOf(pk[i])) != '0) begin
            live[i] = 0;
            break;
          end
        end
      end
    end
    eValid = '0; eWave = '0; eBlk = '0; eRdy = '0;
    for (int r = 0; r < NUM_RES; r++) begin
      if (live[r]) begin
        eValid[r] = 1'b1;
        eWave[r*WAVE_W +: WAVE_W] = WAVE_W'(pk[r]);
        eBlk[pk[r]] = 1'b1;
      end else if (got[r]) begin
        eRdy[pk[r]] = 1'b1;
      end
      if (got[r]) mPtr[r] = pk[r];
    end
    eRdy = eRdy & ~eBlk;
    @(posedge clk);
    @(negedge clk);
    check(tag, "dispValid", 64'(dispValid), 64'(eValid));
    check(tag, "dispWave", 64'(dispWave), 64'(eWave));
    check(tag, "statusBlocked", 64'(statusBlocked), 64'(eBlk));
    check(tag, "statusReady", 64'(statusReady), 64'(eRdy));
  endtask

  task automatic doReset();
    rst = 1'b1;
    readyMask = '1;
    @(posedge clk);
    @(negedge clk);
    check("R9", "dispValid", 64'(dispValid), 64'd0);
    check("R9", "statusBlocked", 64'(statusBlocked), 64'd0);
    check("R9", "statusReady", 64'(statusReady), 64'd0);
    for (int r = 0; r < NUM_RES; r++) mPtr[r] = 0;
    rst = 1'b0;
    readyMask = '0;
  endtask

  task automatic clearAll();
    readyMask = '0;
    waveSimd  = '0;
    waveBanks = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < NUM_RES; r++) mPtr[r] = 0;
    @(negedge clk);
    doReset();

    // R2: nothing ready
    clearAll();
    step("R2");

    // R4: pointer starts at 0, so full mask yields 1, 2, 3; then wraps through 0
    clearAll();
    readyMask[2*NUM_WAVES +: NUM_WAVES] = '1;
    for (int n = 0; n < 3; n++) step("R4");
    readyMask[2*NUM_WAVES +: NUM_WAVES] = 8'b0000_0011;
    step("R4");

    // R5: gmem pick on SIMD 1 with overlapping banks empties SIMD slot 0
    clearAll();
    setWave(2, 1, 4'b0011); setWave(5, 1, 4'b0010);
    setReady(0, 2); setReady(NUM_SIMD, 5);
    step("R5");

    // R6: disjoint banks, then different SIMD ids
    setWave(5, 1, 4'b1000);
    step("R6");
    setWave(5, 3, 4'b0011);
    step("R6");

    // R7: only the lowest conflicting slot is displaced
    clearAll();
    setWave(1, 2, 4'b0100); setWave(2, 2, 4'b0110); setWave(6, 2, 4'b0100);
    setReady(0, 1); setReady(1, 2); setReady(NUM_SIMD, 6);
    step("R7");

    // R8: two SIMD picks sharing banks both survive
    clearAll();
    setWave(3, 0, 4'b1111); setWave(4, 0, 4'b1111);
    setReady(0, 3); setReady(1, 4);
    step("R8");

    // R10: gmem pipe beats smem pipe
    clearAll();
    setWave(3, 1, 4'b0001); setWave(4, 1, 4'b0001);
    setReady(NUM_SIMD, 3); setReady(NUM_SIMD + 1, 4);
    step("R10");

    // R7 chain: gmem empties SIMD slot 0, smem skips it and empties gmem
    clearAll();
    setWave(0, 3, 4'b0001); setWave(3, 3, 4'b0001); setWave(4, 3, 4'b0001);
    setReady(0, 0); setReady(NUM_SIMD, 3); setReady(NUM_SIMD + 1, 4);
    step("R7");

    // R5: same wave picked by two resources, one copy displaced: only blocked reported
    clearAll();
    setWave(6, 0, 4'b0010);
    setReady(0, 6); setReady(NUM_SIMD, 6);
    step("R5");

    // R1 R3: random traffic with narrow SIMD ids and banks for frequent collisions
    for (int n = 0; n < 2000; n++) begin
      for (int w = 0; w < NUM_WAVES; w++)
        setWave(w, int'($urandom % 2), NUM_BANKS'($urandom));
      readyMask = {$urandom, $urandom} & {$urandom, $urandom};
      step((n % 2 == 0) ? "R1" : "R3");
      if (n == 1000) doReset();
    end

    // R9: reset mid-run then check pointer restarted at 0
    doReset();
    readyMask[0 +: NUM_WAVES] = '1;
    step("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule